// File: doc/BRIEF.md
# Zero-Page Accumulator Processor

A small multicycle processor with a 16-bit accumulator, an 8-bit data bus and a 16-bit address bus. Every instruction is two bytes long: an opcode byte followed by an operand byte. Most operands name a location in the first 256 bytes of memory, and that location is used either as 16-bit data or as a 16-bit pointer for indirect access. No adder acts on data. Increment and decrement by two are done by looking up a byte in a table held in ROM.

Out of reset the processor reads a 16-bit start address from ROM and begins fetching there. Each clock is one bus cycle or one internal cycle. A read cycle pulls the read strobe low, and the external memory must present the byte before the next rising edge. A write cycle pulls the write strobe low, with the address and data valid for that clock. Address decoding (RAM at 0x0000–0x3FFF, I/O at 0x4000–0x7FFF, ROM at 0x8000–0xBFFF) and the table contents are supplied by the system around the block.

Top module: `zpacc_cpu`

## Requirements
- R1: After rstN is released, the first two bus cycles read 0x8000 (low byte) and 0x8001 (high byte). The next cycle fetches an opcode from the 16-bit address formed from those bytes.
- R2: While rstN is low, mrN and mwN are both high. mrN and mwN are never low together. A write cycle drives the stored byte on dataOut in the same clock in which mwN is low.
- R3: An instruction takes an opcode read, an operand read and one internal cycle with both strobes high. Opcodes 0x40/0x50 add 2 bus cycles, 0x60/0x70 add 4, 0xE0/0xD0 add 3 and 0xC0 adds 1. Each read or write of zero page or a pointer target is one cycle, in order: low byte, then high byte.
- R4: Opcode 0x20 sets the accumulator to {0x00, operand}. Opcode 0x30 replaces only its high byte with the operand.
- R5: Opcode 0x40 loads the accumulator, and 0x50 stores it, at zero-page address {0x00, op} (low byte) and {0x00, op+1} (high byte). The +1 wraps within zero page.
- R6: Opcodes 0x60 and 0x70 read a pointer from zero page (low byte at op, high byte at op+1), then load or store the 16-bit accumulator at that pointer (low byte) and at pointer+1 (high byte).
- R7: Opcode 0x80 sets PC[7:0] to the operand. Opcode 0x90 does so only when accumulator bit 7 is 1, and 0xA0 only when it is 0. PC[15:8] stays the high byte of the address that follows the branch instruction.
- R8: Opcode 0xB0 sets PC to {operand, 0x00}.
- R9: Opcode 0xC0 reads the byte at address {operand, accumulator low byte} and writes it into the accumulator low byte. The high byte is kept.
- R10: Opcode 0xE0 loads the byte at the zero-page pointer into the accumulator low byte and keeps the high byte. Opcode 0xD0 writes only the accumulator low byte to the pointer target.
- R11: Any opcode byte other than 0x20, 0x30, 0x40, 0x50, 0x60, 0x70, 0x80, 0x90, 0xA0, 0xB0, 0xC0, 0xD0 and 0xE0 runs as a three-cycle no-op. It changes neither the accumulator nor the flow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| addr | output | 16 | Bus address |
| dataIn | input | 8 | Read data, sampled at the end of a cycle with mrN low |
| dataOut | output | 8 | Write data, valid while mwN is low |
| mrN | output | 1 | Read strobe, active low |
| mwN | output | 1 | Write strobe, active low |

## Verification
The bench builds the processor with its default start-vector address, 0x8000. With that default it can lay out a vector, a program at 0x8010 and the two lookup tables at 0x8100 and 0x8200 in a sparse memory model. A behavioural model produces the expected bus activity of every clock from the program image. The program covers taken and untaken conditional branches on both values of the sign bit, a page jump, table lookups in both directions and indirect accesses whose pointer sits across a zero-page pair. It also runs an undefined opcode and places trap code after each branch, so a wrong jump corrupts a later store.

// File: rtl/zpacc_pkg.sv
package zpacc_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [7:0] OP_LDLO = 8'h20, OP_LDHI = 8'h30, OP_LDZ = 8'h40, OP_STZ = 8'h50;
  localparam logic [7:0] OP_LDP  = 8'h60, OP_STP  = 8'h70, OP_BR  = 8'h80, OP_BRN = 8'h90;
  localparam logic [7:0] OP_BRZ  = 8'hA0, OP_PAGE = 8'hB0, OP_TBL = 8'hC0, OP_STPB = 8'hD0;
  localparam logic [7:0] OP_LDPB = 8'hE0;

  typedef enum logic [3:0] {
    S_VEC0, S_VEC1, S_OP, S_ARG, S_EXEC, S_Z0, S_Z1, S_P0, S_P1, S_M0, S_M1, S_TBL
  } stateT;

  typedef enum logic [2:0] {AD_PC, AD_VEC0, AD_VEC1, AD_ZP0, AD_ZP1, AD_PTR0, AD_PTR1, AD_TBL} addrSelT;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_VLO, PC_VHI, PC_BR, PC_PAGE} pcOpT;
  typedef enum logic [1:0] {AL_HOLD, AL_DATA, AL_ARG} alOpT;
  typedef enum logic [1:0] {AH_HOLD, AH_DATA, AH_ARG, AH_ZERO} ahOpT;

  typedef struct packed {
    addrSelT addrSel;
    logic    rd;
    logic    wr;
    logic    hiByte;
    pcOpT    pcOp;
    logic    ldArg;
    alOpT    alOp;
    ahOpT    ahOp;
    logic    ldPtrLo;
    logic    ldPtrHi;
  } ctrlT;
endpackage

// File: rtl/zpacc_datapath.sv
module zpacc_datapath
  import zpacc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dataOut,
  output logic              accSign
);
  logic [ADDR_W-1:0] pc, ptr;
  logic [DATA_W-1:0] accLo, accHi, arg, argNext;

  assign argNext = arg + 8'd1;
  assign accSign = accLo[DATA_W-1];
  assign dataOut = ctl.hiByte ? accHi : accLo;

  always_comb begin
    unique case (ctl.addrSel)
      AD_VEC0: addr = RESET_VEC;
      AD_VEC1: addr = RESET_VEC + 16'd1;
      AD_ZP0:  addr = {8'h00, arg};
      AD_ZP1:  addr = {8'h00, argNext};
      AD_PTR0: addr = ptr;
      AD_PTR1: addr = ptr + 16'd1;
      AD_TBL:  addr = {arg, accLo};
      default: addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc <= '0; ptr <= '0; accLo <= '0; accHi <= '0; arg <= '0;
    end else begin
      unique case (ctl.pcOp)
        PC_INC:  pc <= pc + 16'd1;
        PC_VLO:  pc[7:0] <= dataIn;
        PC_VHI:  pc[15:8] <= dataIn;
        PC_BR:   pc[7:0] <= arg;
        PC_PAGE: pc <= {arg, 8'h00};
        default: ;
      endcase
      if (ctl.ldArg) arg <= dataIn;
      if (ctl.ldPtrLo) ptr[7:0] <= dataIn;
      if (ctl.ldPtrHi) ptr[15:8] <= dataIn;
      unique case (ctl.alOp)
        AL_DATA: accLo <= dataIn;
        AL_ARG:  accLo <= arg;
        default: ;
      endcase
      unique case (ctl.ahOp)
        AH_DATA: accHi <= dataIn;
        AH_ARG:  accHi <= arg;
        AH_ZERO: accHi <= '0;
        default: ;
      endcase
    end
  end

  // R7
  br_keep_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcOp == PC_BR |=> pc[15:8] == $past(pc[15:8]) && pc[7:0] == $past(arg));

  // R8
  page_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcOp == PC_PAGE |=> pc[7:0] == 8'h00);
endmodule

// File: rtl/zpacc_ctrl.sv
module zpacc_ctrl
  import zpacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              accSign,
  output ctrlT              ctl
);
  stateT state, stateNext;
  logic [DATA_W-1:0] ir;
  logic isStore;

  assign isStore = (ir == OP_STZ) || (ir == OP_STP) || (ir == OP_STPB);

  always_comb begin
    ctl = '{addrSel: AD_PC, rd: 1'b0, wr: 1'b0, hiByte: 1'b0, pcOp: PC_HOLD, ldArg: 1'b0,
            alOp: AL_HOLD, ahOp: AH_HOLD, ldPtrLo: 1'b0, ldPtrHi: 1'b0};
    stateNext = S_OP;
    unique case (state)
      S_VEC0: begin ctl.addrSel = AD_VEC0; ctl.rd = 1'b1; ctl.pcOp = PC_VLO; stateNext = S_VEC1; end
      S_VEC1: begin ctl.addrSel = AD_VEC1; ctl.rd = 1'b1; ctl.pcOp = PC_VHI; end
      S_OP:   begin ctl.rd = 1'b1; ctl.pcOp = PC_INC; stateNext = S_ARG; end
      S_ARG:  begin ctl.rd = 1'b1; ctl.pcOp = PC_INC; ctl.ldArg = 1'b1; stateNext = S_EXEC; end
      S_EXEC: begin
        unique case (ir)
          OP_LDLO: begin ctl.alOp = AL_ARG; ctl.ahOp = AH_ZERO; end
          OP_LDHI: ctl.ahOp = AH_ARG;
          OP_LDZ, OP_STZ: stateNext = S_Z0;
          OP_LDP, OP_STP, OP_LDPB, OP_STPB: stateNext = S_P0;
          OP_BR:   ctl.pcOp = PC_BR;
          OP_BRN:  if (accSign)  ctl.pcOp = PC_BR;
          OP_BRZ:  if (!accSign) ctl.pcOp = PC_BR;
          OP_PAGE: ctl.pcOp = PC_PAGE;
          OP_TBL:  stateNext = S_TBL;
          default: ;
        endcase
      end
      S_Z0: begin
        ctl.addrSel = AD_ZP0; ctl.wr = isStore; ctl.rd = !isStore;
        if (!isStore) ctl.alOp = AL_DATA;
        stateNext = S_Z1;
      end
      S_Z1: begin
        ctl.addrSel = AD_ZP1; ctl.wr = isStore; ctl.rd = !isStore; ctl.hiByte = 1'b1;
        if (!isStore) ctl.ahOp = AH_DATA;
      end
      S_P0: begin ctl.addrSel = AD_ZP0; ctl.rd = 1'b1; ctl.ldPtrLo = 1'b1; stateNext = S_P1; end
      S_P1: begin ctl.addrSel = AD_ZP1; ctl.rd = 1'b1; ctl.ldPtrHi = 1'b1; stateNext = S_M0; end
      S_M0: begin
        ctl.addrSel = AD_PTR0; ctl.wr = isStore; ctl.rd = !isStore;
        if (!isStore) ctl.alOp = AL_DATA;
        if (ir == OP_LDP || ir == OP_STP) stateNext = S_M1;
      end
      S_M1: begin
        ctl.addrSel = AD_PTR1; ctl.wr = isStore; ctl.rd = !isStore; ctl.hiByte = 1'b1;
        if (!isStore) ctl.ahOp = AH_DATA;
      end
      S_TBL: begin ctl.addrSel = AD_TBL; ctl.rd = 1'b1; ctl.alOp = AL_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_VEC0;
      ir    <= '0;
    end else begin
      state <= stateNext;
      if (state == S_OP) ir <= dataIn;
    end
  end

  // R2 R5 R6 R10
  store_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> (ir == OP_STZ || ir == OP_STP || ir == OP_STPB));

  // R3
  exec_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_EXEC |-> !ctl.rd && !ctl.wr && $past(state) == S_ARG);
endmodule

// File: rtl/zpacc_cpu.sv
module zpacc_cpu
  import zpacc_pkg::*;
#(
  parameter logic [15:0] RESET_VEC = 16'h8000
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [15:0] addr,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  output logic        mrN,
  output logic        mwN
);
  ctrlT ctl;
  logic accSign;

  zpacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .accSign(accSign), .ctl(ctl)
  );

  zpacc_datapath #(.RESET_VEC(RESET_VEC)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .addr(addr), .dataOut(dataOut), .accSign(accSign)
  );

  assign mrN = !(ctl.rd && rstN);
  assign mwN = !(ctl.wr && rstN);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!mrN && !mwN));
endmodule

// File: tb/zpacc_cpu_test.sv
`timescale 1ns/1ps
module zpacc_cpu_test;
  logic clk = 1'b0;
  logic rstN;
  logic [15:0] addr;
  logic [7:0] dataIn, dataOut;
  logic mrN, mwN;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zpacc_cpu uut (.clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
                 .dataOut(dataOut), .mrN(mrN), .mwN(mwN));

  // sparse memories: pages 0x00, 0x80, 0x81, 0x82, 0x90
  logic [7:0] busMem [0:1279];
  logic [7:0] refMem [0:1279];
  logic [25:0] expQ [$];   // {kind, addr, data}; kind 0 idle, 1 read, 2 write

  function automatic int pidx(input logic [15:0] a);
    case (a[15:8])
      8'h00: return 0 + a[7:0];
      8'h80: return 256 + a[7:0];
      8'h81: return 512 + a[7:0];
      8'h82: return 768 + a[7:0];
      8'h90: return 1024 + a[7:0];
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] refRd(input logic [15:0] a);
    int i = pidx(a);
    return (i < 0) ? 8'h00 : refMem[i];
  endfunction

  task automatic refWr(input logic [15:0] a, input logic [7:0] d);
    int i = pidx(a);
    if (i >= 0 && a < 16'h8000) refMem[i] = d;
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] op, input logic [7:0] arg);
    busMem[pidx(a)] = op; busMem[pidx(a + 16'd1)] = arg;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // behavioural instruction model producing per-clock bus expectations
  task automatic buildModel(input int nInstr);
    logic [15:0] pc, a, ptr;
    logic [7:0] op, arg, z1;
    expQ.push_back({2'd1, 16'h8000, 8'h00});
    expQ.push_back({2'd1, 16'h8001, 8'h00});
    pc = {refRd(16'h8001), refRd(16'h8000)};
    a = 16'h0000;
    for (int n = 0; n < nInstr; n++) begin
      op = refRd(pc);  expQ.push_back({2'd1, pc, 8'h00}); pc = pc + 16'd1;
      arg = refRd(pc); expQ.push_back({2'd1, pc, 8'h00}); pc = pc + 16'd1;
      expQ.push_back({2'd0, 16'h0000, 8'h00});
      z1 = arg + 8'd1;
      ptr = {refRd({8'h00, z1}), refRd({8'h00, arg})};
      case (op)
        8'h20: a = {8'h00, arg};
        8'h30: a[15:8] = arg;
        8'h40: begin
          expQ.push_back({2'd1, 8'h00, arg, 8'h00});
          expQ.push_back({2'd1, 8'h00, z1, 8'h00});
          a = {refRd({8'h00, z1}), refRd({8'h00, arg})};
        end
        8'h50: begin
          expQ.push_back({2'd2, 8'h00, arg, a[7:0]});  refWr({8'h00, arg}, a[7:0]);
          expQ.push_back({2'd2, 8'h00, z1, a[15:8]});  refWr({8'h00, z1}, a[15:8]);
        end
        8'h60, 8'h70, 8'hE0, 8'hD0: begin
          expQ.push_back({2'd1, 8'h00, arg, 8'h00});
          expQ.push_back({2'd1, 8'h00, z1, 8'h00});
          if (op == 8'h60) begin
            expQ.push_back({2'd1, ptr, 8'h00});
            expQ.push_back({2'd1, ptr + 16'd1, 8'h00});
            a = {refRd(ptr + 16'd1), refRd(ptr)};
          end else if (op == 8'hE0) begin
            expQ.push_back({2'd1, ptr, 8'h00});
            a[7:0] = refRd(ptr);
          end else begin
            expQ.push_back({2'd2, ptr, a[7:0]}); refWr(ptr, a[7:0]);
            if (op == 8'h70) begin
              expQ.push_back({2'd2, ptr + 16'd1, a[15:8]}); refWr(ptr + 16'd1, a[15:8]);
            end
          end
        end
        8'h80: pc[7:0] = arg;
        8'h90: if (a[7])  pc[7:0] = arg;
        8'hA0: if (!a[7]) pc[7:0] = arg;
        8'hB0: pc = {arg, 8'h00};
        8'hC0: begin
          expQ.push_back({2'd1, arg, a[7:0], 8'h00});
          a[7:0] = refRd({arg, a[7:0]});
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [25:0] e;
    logic [1:0] kObs;
    int cyc;
    string tag;
    rstN = 1'b0;
    dataIn = 8'h00;
    for (int i = 0; i < 1280; i++) busMem[i] = 8'h00;
    for (int i = 0; i < 256; i++) begin
      busMem[pidx(16'h8100 + 16'(i))] = 8'(i + 2);
      busMem[pidx(16'h8200 + 16'(i))] = 8'(i - 2);
    end
    busMem[pidx(16'h8000)] = 8'h10; busMem[pidx(16'h8001)] = 8'h80;
    put(16'h8010, 8'h20, 8'h34); put(16'h8012, 8'h30, 8'h12); put(16'h8014, 8'h50, 8'h10);
    put(16'h8016, 8'h20, 8'h7F); put(16'h8018, 8'h50, 8'h12); put(16'h801A, 8'hC0, 8'h81);
    put(16'h801C, 8'h50, 8'h14); put(16'h801E, 8'hC0, 8'h82); put(16'h8020, 8'hC0, 8'h82);
    put(16'h8022, 8'h50, 8'h16); put(16'h8024, 8'h20, 8'h40); put(16'h8026, 8'h50, 8'h20);
    put(16'h8028, 8'h30, 8'hAB); put(16'h802A, 8'h70, 8'h20); put(16'h802C, 8'h20, 8'h99);
    put(16'h802E, 8'hD0, 8'h20); put(16'h8030, 8'h40, 8'h10); put(16'h8032, 8'hE0, 8'h20);
    put(16'h8034, 8'h50, 8'h18); put(16'h8036, 8'h60, 8'h20); put(16'h8038, 8'h50, 8'h1A);
    put(16'h803A, 8'hA0, 8'h00); put(16'h803C, 8'h90, 8'h40); put(16'h803E, 8'h20, 8'h00);
    put(16'h8040, 8'h50, 8'h1C); put(16'h8042, 8'h20, 8'h05); put(16'h8044, 8'h90, 8'h00);
    put(16'h8046, 8'hF0, 8'h55); put(16'h8048, 8'h50, 8'h1E); put(16'h804A, 8'hA0, 8'h50);
    put(16'h804C, 8'h20, 8'hEE); put(16'h804E, 8'h50, 8'h1E); put(16'h8050, 8'hB0, 8'h90);
    put(16'h8052, 8'h20, 8'hEE); put(16'h8054, 8'h50, 8'h1E);
    put(16'h9000, 8'h20, 8'h66); put(16'h9002, 8'h50, 8'h22); put(16'h9004, 8'h80, 8'h04);
    for (int i = 0; i < 1280; i++) refMem[i] = busMem[i];
    buildModel(45);

    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset mrN", 32'(mrN), 32'd1);
    chk("R2 reset mwN", 32'(mwN), 32'd1);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    cyc = 0;
    while (expQ.size() > 0) begin
      e = expQ.pop_front();
      if (!mwN && addr < 16'h8000 && pidx(addr) >= 0) busMem[pidx(addr)] = dataOut;
      dataIn = (pidx(addr) < 0) ? 8'h00 : busMem[pidx(addr)];
      kObs = (!mrN && !mwN) ? 2'd3 : (!mrN ? 2'd1 : (!mwN ? 2'd2 : 2'd0));
      tag = (cyc < 2) ? "R1 vector read" : ((e[25:24] == 2'd0) ? "R3 internal cycle" : "R2 R3 bus cycle");
      tag = $sformatf("%s at cycle %0d", tag, cyc);
      if (e[25:24] == 2'd0)      chk(tag, {30'd0, kObs}, {30'd0, e[25:24]});
      else if (e[25:24] == 2'd1) chk(tag, {14'd0, kObs, addr}, {14'd0, e[25:8]});
      else                       chk(tag, {6'd0, kObs, addr, dataOut}, {6'd0, e});
      cyc++;
      @(negedge clk);
      #1;
    end

    chk("R5 store low byte", 32'(busMem[16'h10]), 32'h34);
    chk("R5 store high byte", 32'(busMem[16'h11]), 32'h12);
    chk("R4 immediate low clears high", 32'({busMem[16'h13], busMem[16'h12]}), 32'h007F);
    chk("R9 increment table", 32'(busMem[16'h14]), 32'h81);
    chk("R9 decrement table twice", 32'(busMem[16'h16]), 32'h7D);
    chk("R10 byte store keeps neighbour", 32'({busMem[16'h41], busMem[16'h40]}), 32'hAB99);
    chk("R10 byte load keeps high", 32'({busMem[16'h19], busMem[16'h18]}), 32'h1299);
    chk("R6 indirect word load", 32'({busMem[16'h1B], busMem[16'h1A]}), 32'hAB99);
    chk("R7 taken minus branch skips", 32'({busMem[16'h1D], busMem[16'h1C]}), 32'hAB99);
    chk("R11 undefined opcode and R7 plus branch", 32'({busMem[16'h1F], busMem[16'h1E]}), 32'h0005);
    chk("R8 page jump", 32'({busMem[16'h23], busMem[16'h22]}), 32'h0066);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule